// File: doc/BRIEF.md
# Register and Memory Decrement Unit

This block executes the one-byte decrement instruction of a small 8-bit processor. A start strobe presents an opcode byte. The block decodes which destination the opcode names: one of seven registers, or the memory byte whose address is held in the HL register pair. It then writes back that operand minus one. The block updates the sign, zero, parity and half-carry flags and leaves the carry flag unchanged.

The register forms finish inside the 4-cycle opcode-fetch machine cycle and produce no bus activity. The memory form adds a 3-cycle read and a 3-cycle write to the same address, which gives 10 cycles in total. One clock cycle corresponds to one T-state. The register file and the flag register stay in the surrounding datapath. The block reads the register file through one port and writes it through another, and it returns a complete new flag byte together with a write enable. An opcode that does not encode this instruction is rejected with a one-cycle flag and has no other effect.

Top module: `dcr_unit`

## Requirements
- R1: An opcode is accepted only when bits 7:6 are 00 and bits 2:0 are 101. Bits 5:3 select the destination: 000 B, 001 C, 010 D, 011 E, 100 H, 101 L, 110 memory at HL, 111 A. The register index driven on `rf_raddr` and `rf_waddr` equals bits 5:3.
- R2: The value written back is the operand minus one modulo 256, so 00h becomes FFh. It goes to the same register or to the same memory byte.
- R3: The flag byte uses bit 7 for sign (bit 7 of the result), bit 6 for zero (result is 00h) and bit 2 for parity (1 when the result has an even number of one bits).
- R4: The half-carry flag sits in bit 4. It is 0 only when the low nibble of the operand is 0. For example, operand ABh gives AAh with half-carry=1, sign=1, parity=1 and zero=0.
- R5: Flag bits 0 (carry), 1, 3 and 5 of `flag_out` are copied unchanged from `flag_in`.
- R6: Number the cycles 1, 2, 3 and so on after the edge that samples start. For a register form, `rf_we` and `flag_we` are high only in cycle 4, neither memory strobe rises, and `done` is high only in cycle 5.
- R7: For the memory form, `mem_rd` is high in cycles 5 to 7 and `mem_wr` is high in cycles 8 to 10. Both strobes carry the HL value that was sampled with start. `flag_we` is high only in cycle 10, `done` is high only in cycle 11, and `rf_we` stays low.
- R8: An illegal opcode raises `illegal` for cycle 1 only. It causes no busy cycle, no strobe, no flag write and no `done`.
- R9: A start that arrives while `busy` is high is ignored.
- R10: After reset, `busy`, `done`, `illegal`, `rf_we`, `flag_we`, `mem_rd` and `mem_wr` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Opcode present strobe |
| opcode | input | 8 | Instruction byte |
| hl | input | 16 | Current contents of the HL pair |
| rf_raddr | output | 3 | Register file read index |
| rf_rdata | input | 8 | Register file read data |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 3 | Register file write index |
| rf_wdata | output | 8 | Register file write data |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_rdata | input | 8 | Memory read data, registered by the memory |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| flag_in | input | 8 | Current flag register |
| flag_we | output | 1 | Flag register write enable |
| flag_out | output | 8 | New flag byte |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle illegal opcode pulse |

## Verification
On every cycle, the assertions check the following:
- Read and write strobes are never high together.
- A write always follows a read at an unchanged address.
- Register and bus write-back never overlap.
- `done` is a single-cycle pulse that always follows a flag write.
- Carry passes through and the zero flag agrees with the written data.
- A rejected opcode does nothing else.

The following can only be shown by the directed scenarios:
- Exact cycle positions of the strobes.
- The arithmetic of each result and flag byte against independently computed values.
- That registers other than the destination and neighbouring memory bytes stay unchanged.
- That a start issued mid-instruction is dropped.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_FETCH, PH_MRD, PH_MWR} phase_e;
  localparam int FLAG_W = 8;
  localparam int FL_S   = 7;
  localparam int FL_Z   = 6;
  localparam int FL_AC  = 4;
  localparam int FL_P   = 2;
  localparam logic [FLAG_W-1:0] FL_KEEP = 8'h2B;
  localparam logic [2:0] DST_MEM = 3'b110;
endpackage

// File: rtl/dcr_decode.sv
module dcr_decode (
  input  logic [7:0] opcode,
  output logic       legal,
  output logic [2:0] dst,
  output logic       is_mem
);
  always_comb begin
    legal  = (opcode[7:6] == 2'b00) && (opcode[2:0] == 3'b101);
    dst    = opcode[5:3];
    is_mem = (opcode[5:3] == dcr_pkg::DST_MEM);
  end
endmodule

// File: rtl/dcr_alu.sv
module dcr_alu #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] result,
  output logic              sgn,
  output logic              zero,
  output logic              par,
  output logic              aux
);
  logic [DATA_W:0] sum;
  logic [4:0]      nib;
  always_comb begin
    // add the two's complement of one
    sum    = {1'b0, operand} + {1'b0, {DATA_W{1'b1}}};
    result = sum[DATA_W-1:0];
    nib    = {1'b0, operand[3:0]} + 5'h0F;
    aux    = nib[4];
    sgn    = result[DATA_W-1];
    zero   = (result == '0);
    par    = ~^result;
  end
endmodule

// File: rtl/dcr_seq.sv
module dcr_seq #(
  parameter int FETCH_T = 4,
  parameter int MEM_T   = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            go,
  input  logic            mem_form,
  output dcr_pkg::phase_e phase,
  output logic            fetch_cap,
  output logic            fetch_last,
  output logic            rd_last,
  output logic            wr_last
);
  import dcr_pkg::*;
  localparam int TMAX = (FETCH_T > MEM_T) ? FETCH_T : MEM_T;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] T_F   = TW'(FETCH_T);
  localparam logic [TW-1:0] T_FC  = TW'(FETCH_T - 1);
  localparam logic [TW-1:0] T_M   = TW'(MEM_T);
  localparam logic [TW-1:0] T_ONE = TW'(1);

  phase_e        ph_q, ph_d;
  logic [TW-1:0] t_q, t_d;

  always_comb begin
    ph_d = ph_q;
    t_d  = t_q;
    unique case (ph_q)
      PH_IDLE: if (go) begin ph_d = PH_FETCH; t_d = T_ONE; end
      PH_FETCH: begin
        if (t_q == T_F) begin
          ph_d = mem_form ? PH_MRD : PH_IDLE;
          t_d  = mem_form ? T_ONE : '0;
        end else t_d = t_q + T_ONE;
      end
      PH_MRD: begin
        if (t_q == T_M) begin ph_d = PH_MWR; t_d = T_ONE; end
        else t_d = t_q + T_ONE;
      end
      PH_MWR: begin
        if (t_q == T_M) begin ph_d = PH_IDLE; t_d = '0; end
        else t_d = t_q + T_ONE;
      end
      default: begin ph_d = PH_IDLE; t_d = '0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q <= PH_IDLE;
      t_q  <= '0;
    end else begin
      ph_q <= ph_d;
      t_q  <= t_d;
    end
  end

  assign phase      = ph_q;
  assign fetch_cap  = (ph_q == PH_FETCH) && (t_q == T_FC);
  assign fetch_last = (ph_q == PH_FETCH) && (t_q == T_F);
  assign rd_last    = (ph_q == PH_MRD)   && (t_q == T_M);
  assign wr_last    = (ph_q == PH_MWR)   && (t_q == T_M);
endmodule

// File: rtl/dcr_unit.sv
module dcr_unit #(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 16,
  parameter int RSEL_W  = 3,
  parameter int FETCH_T = 4,
  parameter int MEM_T   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [7:0]        opcode,
  input  logic [ADDR_W-1:0] hl,
  output logic [RSEL_W-1:0] rf_raddr,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic              rf_we,
  output logic [RSEL_W-1:0] rf_waddr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [7:0]        flag_in,
  output logic              flag_we,
  output logic [7:0]        flag_out,
  output logic              busy,
  output logic              done,
  output logic              illegal
);
  import dcr_pkg::*;

  logic        dec_legal, dec_mem;
  logic [2:0]  dec_dst;
  phase_e      phase;
  logic        fetch_cap, fetch_last, rd_last, wr_last;
  logic        accept, go;
  logic [RSEL_W-1:0] dst_q;
  logic        mem_q;
  logic [ADDR_W-1:0] hl_q;
  logic [DATA_W-1:0] op_q;
  logic [DATA_W-1:0] res;
  logic        f_s, f_z, f_p, f_ac;
  logic        done_q, ill_q;

  dcr_decode u_dec (
    .opcode (opcode),
    .legal  (dec_legal),
    .dst    (dec_dst),
    .is_mem (dec_mem)
  );

  assign accept = start && (phase == PH_IDLE);
  assign go     = accept && dec_legal;

  dcr_seq #(.FETCH_T(FETCH_T), .MEM_T(MEM_T)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .go         (go),
    .mem_form   (dec_mem && go ? 1'b1 : mem_q),
    .phase      (phase),
    .fetch_cap  (fetch_cap),
    .fetch_last (fetch_last),
    .rd_last    (rd_last),
    .wr_last    (wr_last)
  );

  dcr_alu #(.DATA_W(DATA_W)) u_alu (
    .operand (op_q),
    .result  (res),
    .sgn     (f_s),
    .zero    (f_z),
    .par     (f_p),
    .aux     (f_ac)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dst_q  <= '0;
      mem_q  <= 1'b0;
      hl_q   <= '0;
      op_q   <= '0;
      done_q <= 1'b0;
      ill_q  <= 1'b0;
    end else begin
      if (go) begin
        dst_q <= RSEL_W'(dec_dst);
        mem_q <= dec_mem;
        hl_q  <= hl;
      end
      if (fetch_cap && !mem_q) op_q <= rf_rdata;
      if (rd_last)             op_q <= mem_rdata;
      done_q <= flag_we;
      ill_q  <= accept && !dec_legal;
    end
  end

  always_comb begin
    rf_raddr  = dst_q;
    rf_waddr  = dst_q;
    rf_we     = fetch_last && !mem_q;
    rf_wdata  = res;
    mem_rd    = (phase == PH_MRD);
    mem_wr    = (phase == PH_MWR);
    mem_addr  = (mem_rd || mem_wr) ? hl_q : '0;
    mem_wdata = res;
    flag_we   = rf_we || wr_last;
    flag_out  = flag_in & FL_KEEP;
    flag_out[FL_S]  = f_s;
    flag_out[FL_Z]  = f_z;
    flag_out[FL_AC] = f_ac;
    flag_out[FL_P]  = f_p;
    busy      = (phase != PH_IDLE);
    done      = done_q;
    illegal   = ill_q;
  end
endmodule

// File: rtl/dcr_unit_chk.sv
module dcr_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic [7:0]  opcode,
  input logic [2:0]  rf_raddr,
  input logic        rf_we,
  input logic [2:0]  rf_waddr,
  input logic [7:0]  rf_wdata,
  input logic [15:0] mem_addr,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic [7:0]  mem_wdata,
  input logic [7:0]  flag_in,
  input logic        flag_we,
  input logic [7:0]  flag_out,
  input logic        busy,
  input logic        done,
  input logic        illegal
);
  AST_RW_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr)); // R7
  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_wr) |-> $past(mem_rd)); // R7
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && $past(mem_rd)) |-> (mem_addr == $past(mem_addr))); // R7
  AST_REG_NO_BUS: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> (!mem_rd && !mem_wr)); // R6
  AST_SAME_REG: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> (rf_waddr == rf_raddr)); // R1
  AST_WB_ONE: assert property (@(posedge clk) disable iff (rst)
    rf_we |=> !rf_we); // R6
  AST_DONE_ONE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6
  AST_DONE_AFTER_WB: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(flag_we)); // R7
  AST_CY_KEEP: assert property (@(posedge clk) disable iff (rst)
    flag_we |-> (flag_out[0] == flag_in[0])); // R5
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
    flag_we |-> (flag_out[6] == (((rf_we ? rf_wdata : mem_wdata)) == 8'h00))); // R3
  AST_ILL_QUIET: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!busy && !rf_we && !mem_rd && !mem_wr && !flag_we && !done)); // R8
  AST_ILL_CAUSE: assert property (@(posedge clk) disable iff (rst)
    illegal |-> ($past(start) && !$past(busy) &&
                 (($past(opcode[2:0]) != 3'b101) || ($past(opcode[7:6]) != 2'b00)))); // R8
endmodule

bind dcr_unit dcr_unit_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .opcode(opcode),
  .rf_raddr(rf_raddr), .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
  .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
  .flag_in(flag_in), .flag_we(flag_we), .flag_out(flag_out),
  .busy(busy), .done(done), .illegal(illegal)
);

// File: tb/dcr_unit_tb.sv
module dcr_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [15:0] hl = 16'h4050;
  logic [2:0]  rf_raddr, rf_waddr;
  logic [7:0]  rf_rdata, rf_wdata, mem_rdata, mem_wdata, flag_out;
  logic [15:0] mem_addr;
  logic        rf_we, mem_rd, mem_wr, flag_we, busy, done, illegal;
  logic [7:0]  fl;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  dcr_unit u_dut (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode), .hl(hl),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
    .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .flag_in(fl), .flag_we(flag_we), .flag_out(flag_out),
    .busy(busy), .done(done), .illegal(illegal)
  );

  // datapath models; setup writes go through request signals
  logic [7:0] rf [8];
  logic [7:0] mem [256];
  logic       set_rf = 1'b0, set_mem = 1'b0, set_fl = 1'b0;
  logic [7:0] set_idx = 8'h00, set_val = 8'h00;

  assign rf_rdata = rf[rf_raddr];

  always @(posedge clk) begin
    if (set_rf)  rf[set_idx[2:0]] <= set_val;
    if (set_mem) mem[set_idx] <= set_val;
    if (set_fl)  fl <= set_val;
    if (rf_we)   rf[rf_waddr] <= rf_wdata;
    if (flag_we) fl <= flag_out;
    if (mem_rd)  mem_rdata <= mem[mem_addr[7:0]];
    if (mem_wr)  mem[mem_addr[7:0]] <= mem_wdata;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic put(input bit kind_rf, input bit kind_fl, input logic [7:0] idx,
                     input logic [7:0] val);
    set_rf = kind_rf && !kind_fl; set_mem = !kind_rf && !kind_fl; set_fl = kind_fl;
    set_idx = idx; set_val = val;
    @(negedge clk);
    set_rf = 1'b0; set_mem = 1'b0; set_fl = 1'b0;
  endtask

  function automatic logic [7:0] expf(input logic [7:0] opnd, input logic [7:0] fin);
    logic [7:0] r;
    r = opnd - 8'h01;
    return (fin & 8'h2B) | {r[7], r == 8'h00, 1'b0, opnd[3:0] != 4'h0, 1'b0, ~^r, 2'b00};
  endfunction

  int we_first, we_cnt, rd_first, rd_cnt, wr_first, wr_cnt;
  int fw_first, fw_cnt, dn_first, dn_cnt, il_first, il_cnt, busy_cnt, addr_bad;

  task automatic run_op(input logic [7:0] op, input bit poke);
    we_first = 0; we_cnt = 0; rd_first = 0; rd_cnt = 0; wr_first = 0; wr_cnt = 0;
    fw_first = 0; fw_cnt = 0; dn_first = 0; dn_cnt = 0; il_first = 0; il_cnt = 0;
    busy_cnt = 0; addr_bad = 0;
    opcode = op; start = 1'b1;
    for (int k = 1; k <= 14; k++) begin
      @(negedge clk);
      if (rf_we)   begin we_cnt++; if (we_first == 0) we_first = k; end
      if (mem_rd)  begin rd_cnt++; if (rd_first == 0) rd_first = k; end
      if (mem_wr)  begin wr_cnt++; if (wr_first == 0) wr_first = k; end
      if (flag_we) begin fw_cnt++; if (fw_first == 0) fw_first = k; end
      if (done)    begin dn_cnt++; if (dn_first == 0) dn_first = k; end
      if (illegal) begin il_cnt++; if (il_first == 0) il_first = k; end
      if (busy) busy_cnt++;
      if ((mem_rd || mem_wr) && mem_addr != hl) addr_bad++;
      start = 1'b0;
      if (poke && k == 2) begin start = 1'b1; opcode = 8'h05; end
    end
    start = 1'b0;
  endtask

  task automatic preset_regs();
    for (int i = 0; i < 8; i++) put(1'b1, 1'b0, 8'(i), 8'(8'h31 + 8'(i) * 8'h11));
  endtask

  task automatic test_reg(input logic [2:0] code, input logic [7:0] init,
                          input logic [7:0] fin);
    logic [7:0] snap [8];
    logic [7:0] ef;
    preset_regs();
    put(1'b1, 1'b0, {5'b0, code}, init);
    put(1'b0, 1'b1, 8'h00, fin);
    for (int i = 0; i < 8; i++) snap[i] = rf[i];
    ef = expf(init, fin);
    run_op({2'b00, code, 3'b101}, 1'b0);
    chk(rf[code] == init - 8'h01, "R2", "register result", rf[code], init - 8'h01);
    chk(fl == ef, "R3", "flag byte", fl, ef);
    chk(fl[0] == fin[0], "R5", "carry kept", fl[0], fin[0]);
    chk(we_first == 4 && we_cnt == 1 && fw_first == 4 && fw_cnt == 1, "R6",
        "write-back cycle", we_first * 16 + we_cnt, 8'h41);
    chk(rd_cnt == 0 && wr_cnt == 0, "R6", "bus strobes", rd_cnt + wr_cnt, 0);
    chk(dn_first == 5 && dn_cnt == 1, "R6", "done cycle", dn_first, 5);
    for (int i = 0; i < 8; i++)
      if (i != int'(code))
        chk(rf[i] == snap[i], "R1", "other register", rf[i], snap[i]);
  endtask

  task automatic test_mem(input logic [7:0] init, input logic [7:0] fin);
    logic [7:0] ef;
    logic [7:0] snap [8];
    preset_regs();
    put(1'b0, 1'b0, 8'h50, init);
    put(1'b0, 1'b0, 8'h51, 8'h77);
    put(1'b0, 1'b1, 8'h00, fin);
    for (int i = 0; i < 8; i++) snap[i] = rf[i];
    ef = expf(init, fin);
    run_op(8'h35, 1'b0);
    chk(mem[8'h50] == init - 8'h01, "R2", "memory result", mem[8'h50], init - 8'h01);
    chk(mem[8'h51] == 8'h77, "R7", "neighbour byte", mem[8'h51], 8'h77);
    chk(rd_first == 5 && rd_cnt == 3, "R7", "read window", rd_first * 16 + rd_cnt, 8'h53);
    chk(wr_first == 8 && wr_cnt == 3, "R7", "write window", wr_first * 16 + wr_cnt, 8'h83);
    chk(fw_first == 10 && fw_cnt == 1, "R7", "flag write cycle", fw_first, 10);
    chk(dn_first == 11 && dn_cnt == 1, "R7", "done cycle", dn_first, 11);
    chk(addr_bad == 0, "R7", "address mismatches", addr_bad, 0);
    chk(we_cnt == 0, "R7", "register writes", we_cnt, 0);
    chk(fl == ef, "R4", "flag byte", fl, ef);
    for (int i = 0; i < 8; i++)
      chk(rf[i] == snap[i], "R7", "register untouched", rf[i], snap[i]);
  endtask

  task automatic test_illegal(input logic [7:0] op);
    logic [7:0] snap [8];
    logic [7:0] fsnap, msnap;
    preset_regs();
    put(1'b0, 1'b1, 8'h00, 8'hD5);
    for (int i = 0; i < 8; i++) snap[i] = rf[i];
    fsnap = fl; msnap = mem[8'h50];
    run_op(op, 1'b0);
    chk(il_first == 1 && il_cnt == 1, "R8", "illegal pulse", il_first * 16 + il_cnt, 8'h11);
    chk(busy_cnt == 0 && we_cnt == 0 && rd_cnt == 0 && wr_cnt == 0 && fw_cnt == 0 &&
        dn_cnt == 0, "R8", "activity count",
        busy_cnt + we_cnt + rd_cnt + wr_cnt + fw_cnt + dn_cnt, 0);
    chk(fl == fsnap && mem[8'h50] == msnap, "R8", "flags", fl, fsnap);
    for (int i = 0; i < 8; i++)
      chk(rf[i] == snap[i], "R1", "register after reject", rf[i], snap[i]);
  endtask

  task automatic test_busy();
    preset_regs();
    put(1'b1, 1'b0, 8'd7, 8'h20);
    put(1'b1, 1'b0, 8'd0, 8'h40);
    put(1'b0, 1'b1, 8'h00, 8'h00);
    run_op(8'h3D, 1'b1);
    chk(we_cnt == 1 && busy_cnt == 4, "R9", "writes and busy", we_cnt * 16 + busy_cnt, 8'h14);
    chk(rf[0] == 8'h40, "R9", "second start dropped", rf[0], 8'h40);
    chk(rf[7] == 8'h1F, "R9", "first op result", rf[7], 8'h1F);
    chk(il_cnt == 0, "R9", "no reject", il_cnt, 0);
  endtask

  task automatic test_reset();
    chk(!busy && !done && !illegal && !rf_we && !flag_we && !mem_rd && !mem_wr, "R10",
        "outputs after reset",
        {busy, done, illegal, rf_we, flag_we, mem_rd, mem_wr}, 0);
  endtask

  task automatic test_sample();
    // ABh -> AAh: half-carry 1, sign 1, parity 1, zero 0
    test_reg(3'b111, 8'hAB, 8'h01);
    chk(rf[7] == 8'hAA, "R4", "sample result", rf[7], 8'hAA);
    chk(fl[7] && !fl[6] && fl[4] && fl[2] && fl[0], "R4", "sample flags", fl, 8'h95);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R6 watchdog expired: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    fl = 8'h00;
    mem_rdata = 8'h00;
    for (int i = 0; i < 8; i++) rf[i] = 8'h00;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_sample();
    test_reg(3'b000, 8'h00, 8'h2A);   // wrap to FFh, carry 0
    test_reg(3'b001, 8'h01, 8'h01);   // zero result
    test_reg(3'b101, 8'h10, 8'h2B);   // half-carry 0
    test_reg(3'b010, 8'h81, 8'h00);
    test_reg(3'b011, 8'h7F, 8'h09);
    test_reg(3'b100, 8'h5C, 8'h23);
    test_mem(8'hAB, 8'h01);
    test_mem(8'h00, 8'h00);
    test_mem(8'h01, 8'h2B);
    test_illegal(8'h3C);
    test_illegal(8'h45);
    test_illegal(8'hF5);
    test_busy();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule